// File: doc/BRIEF.md
# Packet Ring Descriptor and Slot Addressing

This block keeps the bookkeeping for one command ring that lives in host memory and is cut into fixed 64-byte packet slots. A configure strobe loads the ring's base address, its size in bytes and a wrap mode. The block then holds a write index and a read index, each a free-running counter of `IDX_W` bits. From these two indices it drives space used, space left, full and empty. Producers move the write index forward with a strobe and an amount. Consumers move the read index forward the same way. A write step that would put more packets in the ring than it has slots is refused, and a sticky overflow flag is raised.

A separate lookup stream turns a packet index into the byte address of its slot. In full-wrap mode the index wraps at the slot count. In half-wrap mode the ring was given twice the memory it really uses, so the index wraps at half the slot count and the upper half of the allocation maps onto the lower half. The slot count must be a power of two, so the wrap is a mask that is computed once at configure time.

The lookup stream uses valid/ready. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. The address comes out on `rsp_addr` with `rsp_valid` on the next cycle. A pending response holds `rsp_valid` and `rsp_addr` steady until `rsp_ready` is high, and while it waits, `lk_ready` is low. There is one output register and no further buffering.

Top module: `pkt_ring_desc`

## Requirements
- R1: After an accepted configure, the slot count is the byte size divided by 64: `space_left` equals the slot count, `space_used` is 0, `q_empty` is 1 and `q_full` is 0.
- R2: A configure is rejected if any of these holds: the byte size is not a multiple of 64; the resulting slot count is zero or not a power of two; or half-wrap mode (`cfg_half`=1) is asked for with a single slot. A rejected configure sets `cfg_err` and leaves the previous configuration and both indices unchanged. An accepted configure clears `cfg_err`.
- R3: An accepted write step adds `wr_amt` to the write index, and an accepted read step adds `rd_amt` to the read index. `space_used` is the write index minus the read index, and `space_left` is the slot count minus `space_used`.
- R4: A write step is refused when the current `space_used` plus `wr_amt` exceeds the slot count. A refused step leaves the write index unchanged and sets `wr_ovf`, which stays high until the next accepted configure.
- R5: A read step whose `rd_amt` exceeds the current `space_used` is ignored.
- R6: `q_full` is high exactly when `space_left` is 0, and `q_empty` is high exactly when `space_left` equals the slot count.
- R7: In full-wrap mode (`cfg_half`=0), the lookup address is the base plus (index mod slot count) times 64.
- R8: In half-wrap mode (`cfg_half`=1), the lookup address is the base plus (index mod half the slot count) times 64.
- R9: A lookup taken on an edge shows `rsp_valid` one cycle later. While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` holds and `lk_ready` is low.
- R10: An accepted configure sets both indices to zero and clears `wr_ovf`. It takes precedence over any step strobed in the same cycle. Write and read steps in the same cycle are each checked against the `space_used` from before that cycle.
- R11: The indices wrap modulo 2^IDX_W, and space accounting stays correct across that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configure strobe |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_bytes | input | SZ_W | Ring size in bytes |
| cfg_half | input | 1 | 1 selects half-wrap mode |
| cfg_err | output | 1 | Last configure was rejected |
| wr_inc | input | 1 | Write-index step strobe |
| wr_amt | input | AMT_W | Write step size |
| rd_inc | input | 1 | Read-index step strobe |
| rd_amt | input | AMT_W | Read step size |
| space_used | output | SZ_W-6 | Packets in the ring |
| space_left | output | SZ_W-6 | Free slots |
| q_full | output | 1 | No free slot |
| q_empty | output | 1 | No packet held |
| wr_ovf | output | 1 | Sticky refused-write flag |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this edge |
| lk_idx | input | IDX_W | Packet index to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | ADDR_W | Slot byte address |

## Verification
The bench builds the block with `IDX_W`=12, `SZ_W`=16, `AMT_W`=5 and `ADDR_W`=32. A 12-bit index lets a few hundred fill-and-drain rounds carry both counters past 4096, which shows that the subtraction stays correct across the wrap. A 16-bit size field keeps rings of 8 to 16 slots small enough to fill to the brim with single steps. It also lets the bench use misaligned, non-power-of-two and single-slot half-wrap sizes. On the lookup stream the bench throttles `rsp_ready` with a repeating pattern, so the hold and stall rules are exercised in both wrap modes.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int unsigned SLOT_LOG2 = 6;

  typedef enum logic [0:0] {
    WRAP_FULL = 1'b0,
    WRAP_HALF = 1'b1
  } wrap_mode_e;
endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
  import ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SZ_W   = 32,
  localparam int unsigned CNT_W = SZ_W - SLOT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_bytes,
  input  logic              cfg_half,
  output logic              load_o,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  slots_q,
  output logic [CNT_W-1:0]  mask_q,
  output wrap_mode_e        mode_q,
  output logic              err_q
);
  logic [CNT_W-1:0] slots_in;
  logic [CNT_W-1:0] mask_in;
  logic             aligned;
  logic             pow2;
  logic             half_ok;
  logic             good;

  always_comb begin
    slots_in = cfg_bytes[SZ_W-1:SLOT_LOG2];
    aligned  = (cfg_bytes[SLOT_LOG2-1:0] == '0);
    pow2     = (slots_in != '0) && ((slots_in & (slots_in - CNT_W'(1))) == '0);
    half_ok  = !cfg_half || (slots_in != CNT_W'(1));
    good     = aligned && pow2 && half_ok;
    mask_in  = cfg_half ? ((slots_in >> 1) - CNT_W'(1)) : (slots_in - CNT_W'(1));
  end

  assign load_o = cfg_valid && good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      slots_q <= '0;
      mask_q  <= '0;
      mode_q  <= WRAP_FULL;
      err_q   <= 1'b0;
    end else if (cfg_valid) begin
      err_q <= !good;
      if (good) begin
        base_q  <= cfg_base;
        slots_q <= slots_in;
        mask_q  <= mask_in;
        mode_q  <= cfg_half ? WRAP_HALF : WRAP_FULL;
      end
    end
  end

  // R2: a rejected configure leaves the held ring geometry untouched
  assert_bad_cfg_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($stable(slots_q) && $stable(base_q) && $stable(mask_q)));

  // R1: held slot count is always zero (unconfigured) or a power of two
  assert_slots_pow2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slots_q) <= 1);
endmodule

// File: rtl/ring_idx.sv
module ring_idx #(
  parameter int unsigned IDX_W = 64,
  parameter int unsigned CNT_W = 26,
  parameter int unsigned AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] slots,
  input  logic             wr_inc,
  input  logic [AMT_W-1:0] wr_amt,
  input  logic             rd_inc,
  input  logic [AMT_W-1:0] rd_amt,
  output logic [CNT_W-1:0] used_o,
  output logic [CNT_W-1:0] left_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [IDX_W-1:0] diff;
  logic [CNT_W:0]   wr_sum;
  logic             wr_ok, rd_ok;
  logic             ovf_q;

  always_comb begin
    diff    = wr_q - rd_q;
    used_o  = diff[CNT_W-1:0];
    left_o  = slots - used_o;
    full_o  = (left_o == '0);
    empty_o = (left_o == slots);
    wr_sum  = {1'b0, used_o} + (CNT_W+1)'(wr_amt);
    wr_ok   = (wr_sum <= {1'b0, slots});
    rd_ok   = (CNT_W'(rd_amt) <= used_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_inc && wr_ok)  wr_q  <= wr_q + IDX_W'(wr_amt);
      if (wr_inc && !wr_ok) ovf_q <= 1'b1;
      if (rd_inc && rd_ok)  rd_q  <= rd_q + IDX_W'(rd_amt);
    end
  end

  assign ovf_o = ovf_q;

  // R3: occupancy never exceeds the slot count
  assert_used_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    diff <= IDX_W'(slots));

  // R4: overflow flag stays up until a configure is accepted
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !load) |=> ovf_q);

  // R4: the edge that raises overflow did not move the write index
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $stable(wr_q));

  // R10: configure clears both indices and the flag
  assert_cfg_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wr_q == '0 && rd_q == '0 && !ovf_q));
endmodule

// File: rtl/ring_addr.sv
module ring_addr
  import ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  mask,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int unsigned OFF_W = IDX_W + SLOT_LOG2;

  logic [IDX_W-1:0]  idx_m;
  logic [OFF_W-1:0]  offs;
  logic [ADDR_W-1:0] addr_c;
  logic              take;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    idx_m  = lk_idx & IDX_W'(mask);
    offs   = {idx_m, {SLOT_LOG2{1'b0}}};
    addr_c = base + ADDR_W'(offs);
  end

  assign lk_ready = !vld_q || rsp_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (lk_ready) begin
      vld_q <= lk_valid;
      if (take) addr_q <= addr_c;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_addr  = addr_q;

  // R9: a stalled result holds steady
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rsp_ready) |=> (vld_q && $stable(addr_q)));

  // R9: an accepted request yields a result on the next cycle
  assert_take_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> vld_q);

  // R9: stalled output blocks new requests
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rsp_ready) |-> !lk_ready);
endmodule

// File: rtl/pkt_ring_desc.sv
module pkt_ring_desc
  import ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned SZ_W   = 32,
  parameter int unsigned AMT_W  = 8,
  localparam int unsigned CNT_W = SZ_W - SLOT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_bytes,
  input  logic              cfg_half,
  output logic              cfg_err,
  input  logic              wr_inc,
  input  logic [AMT_W-1:0]  wr_amt,
  input  logic              rd_inc,
  input  logic [AMT_W-1:0]  rd_amt,
  output logic [CNT_W-1:0]  space_used,
  output logic [CNT_W-1:0]  space_left,
  output logic              q_full,
  output logic              q_empty,
  output logic              wr_ovf,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  slots_q;
  logic [CNT_W-1:0]  mask_q;
  wrap_mode_e        mode_q;

  ring_cfg #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_bytes(cfg_bytes),
    .cfg_half(cfg_half),
    .load_o(load), .base_q(base_q), .slots_q(slots_q), .mask_q(mask_q),
    .mode_q(mode_q), .err_q(cfg_err)
  );

  ring_idx #(.IDX_W(IDX_W), .CNT_W(CNT_W), .AMT_W(AMT_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(load), .slots(slots_q),
    .wr_inc(wr_inc), .wr_amt(wr_amt), .rd_inc(rd_inc), .rd_amt(rd_amt),
    .used_o(space_used), .left_o(space_left), .full_o(q_full),
    .empty_o(q_empty), .ovf_o(wr_ovf)
  );

  ring_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .base(base_q), .mask(mask_q),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_idx(lk_idx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr)
  );

  // R8: in half-wrap mode the mask covers half the slot count
  assert_half_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WRAP_HALF) |-> ({1'b0, mask_q} + 1'b1 == {1'b0, slots_q >> 1}));

  // R7: in full-wrap mode the mask covers the whole ring
  assert_full_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WRAP_FULL && slots_q != '0) |-> ({1'b0, mask_q} + 1'b1 == {1'b0, slots_q}));
endmodule

// File: tb/test_pkt_ring_desc.sv
`timescale 1ns/1ps
module test_pkt_ring_desc;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 12;
  localparam int SZ_W   = 16;
  localparam int AMT_W  = 5;
  localparam int CNT_W  = SZ_W - 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [SZ_W-1:0] cfg_bytes = '0;
  logic cfg_half = 1'b0;
  logic cfg_err;
  logic wr_inc = 1'b0, rd_inc = 1'b0;
  logic [AMT_W-1:0] wr_amt = '0, rd_amt = '0;
  logic [CNT_W-1:0] space_used, space_left;
  logic q_full, q_empty, wr_ovf;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [IDX_W-1:0] lk_idx = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [ADDR_W-1:0] rsp_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit bp_en = 1'b0;
  int bp_cnt = 0;
  logic [ADDR_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  pkt_ring_desc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SZ_W(SZ_W), .AMT_W(AMT_W)) i_pkt_ring_desc (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
    .cfg_bytes(cfg_bytes), .cfg_half(cfg_half), .cfg_err(cfg_err),
    .wr_inc(wr_inc), .wr_amt(wr_amt), .rd_inc(rd_inc), .rd_amt(rd_amt),
    .space_used(space_used), .space_left(space_left), .q_full(q_full),
    .q_empty(q_empty), .wr_ovf(wr_ovf), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_idx(lk_idx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [ADDR_W-1:0] b, input logic [SZ_W-1:0] n, input logic h);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_base = b; cfg_bytes = n; cfg_half = h;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic step(input logic w, input int wa, input logic r, input int ra);
    @(negedge clk);
    wr_inc = w; wr_amt = AMT_W'(wa); rd_inc = r; rd_amt = AMT_W'(ra);
    @(negedge clk);
    wr_inc = 1'b0; rd_inc = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b, input int idx, input int n);
    return b + ADDR_W'((idx % n) * 64);
  endfunction

  task automatic lookup(input int idx, input logic [ADDR_W-1:0] e);
    @(negedge clk);
    lk_valid = 1'b1; lk_idx = IDX_W'(idx);
    while (!lk_ready) @(negedge clk);
    exp_q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 rsp_valid one cycle after take", rsp_valid, 1);
  endtask

  // back-pressure pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    rsp_ready = bp_en ? ((bp_cnt % 3) != 1) : 1'b1;
  end

  // monitor: score every handshaken result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected response", rsp_addr, 0);
        end else begin
          chk("R7/R8 lookup address", rsp_addr, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [ADDR_W-1:0] b0;
    b0 = 32'h1000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset cfg_err", cfg_err, 0);
    chk("reset wr_ovf", wr_ovf, 0);
    chk("reset rsp_valid", rsp_valid, 0);
    chk("reset space_used", space_used, 0);

    // R1: 512 bytes -> 8 slots
    do_cfg(b0, 512, 1'b0);
    chk("R1 space_left", space_left, 8);
    chk("R1 space_used", space_used, 0);
    chk("R1 empty", q_empty, 1);
    chk("R1 not full", q_full, 0);
    chk("R2 good cfg no err", cfg_err, 0);

    // R3
    step(1, 3, 0, 0);
    chk("R3 used after write 3", space_used, 3);
    chk("R3 left after write 3", space_left, 5);
    step(0, 0, 1, 2);
    chk("R3 used after read 2", space_used, 1);
    // R6
    step(1, 7, 0, 0);
    chk("R6 full", q_full, 1);
    chk("R6 left zero", space_left, 0);
    chk("R6 not empty", q_empty, 0);
    // R4
    step(1, 1, 0, 0);
    chk("R4 ovf set", wr_ovf, 1);
    chk("R4 used unchanged", space_used, 8);
    step(0, 0, 1, 1);
    chk("R4 ovf sticky", wr_ovf, 1);
    chk("R4 read still works", space_used, 7);
    // R5
    step(0, 0, 1, 20);
    chk("R5 oversize read ignored", space_used, 7);
    // R10 same-cycle write and read against old occupancy
    step(1, 1, 1, 3);
    chk("R10 concurrent steps", space_used, 5);

    // R10 reconfigure clears indices, beats a same-cycle step
    @(negedge clk);
    cfg_valid = 1'b1; cfg_base = b0; cfg_bytes = 1024; cfg_half = 1'b0;
    wr_inc = 1'b1; wr_amt = 4;
    @(negedge clk);
    cfg_valid = 1'b0; wr_inc = 1'b0;
    chk("R10 used cleared", space_used, 0);
    chk("R10 left is 16", space_left, 16);
    chk("R10 ovf cleared", wr_ovf, 0);

    // R2 rejected configurations
    step(1, 2, 0, 0);
    do_cfg(32'h2000_0000, 192, 1'b0);
    chk("R2 non-pow2 err", cfg_err, 1);
    chk("R2 size kept", space_left, 14);
    chk("R2 index kept", space_used, 2);
    do_cfg(32'h2000_0000, 100, 1'b0);
    chk("R2 misaligned err", cfg_err, 1);
    do_cfg(32'h2000_0000, 64, 1'b1);
    chk("R2 half with one slot err", cfg_err, 1);
    do_cfg(32'h2000_0000, 0, 1'b0);
    chk("R2 zero size err", cfg_err, 1);
    chk("R2 still kept", space_used, 2);

    // R11 index wrap with 8 slots
    do_cfg(b0, 512, 1'b0);
    chk("R2 err cleared", cfg_err, 0);
    for (int i = 0; i < 520; i++) begin
      step(1, 8, 0, 0);
      if (i % 64 == 0) chk("R11 full during wrap", q_full, 1);
      step(0, 0, 1, 8);
      if (i % 64 == 0) chk("R11 empty during wrap", q_empty, 1);
    end
    step(1, 5, 0, 0);
    chk("R11 used after wrap", space_used, 5);
    chk("R11 left after wrap", space_left, 3);

    // R7 full-wrap lookups with back-pressure
    bp_en = 1'b1;
    lookup(0, exp_addr(b0, 0, 8));
    lookup(5, exp_addr(b0, 5, 8));
    lookup(8, exp_addr(b0, 8, 8));
    lookup(13, exp_addr(b0, 13, 8));
    lookup(4095, exp_addr(b0, 4095, 8));

    // R8 half-wrap: 1024 bytes = 16 slots, wraps at 8
    do_cfg(32'h0040_0000, 1024, 1'b1);
    chk("R8 half cfg accepted", cfg_err, 0);
    lookup(3, exp_addr(32'h0040_0000, 3, 8));
    lookup(8, exp_addr(32'h0040_0000, 8, 8));
    lookup(15, exp_addr(32'h0040_0000, 15, 8));
    lookup(17, exp_addr(32'h0040_0000, 17, 8));

    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R9 all responses drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule